// File: doc/BRIEF.md
# Masked Lane-Wise Low-Word Shuffle Unit

This unit is a one-cycle permute stage for a 512-bit vector register path. The path is split into 128-bit lanes. In each lane, the four 16-bit words of the lower 64 bits are rearranged under one 8-bit selector. The upper 64 bits of every lane pass through unchanged. The same selector drives every lane, and no word ever moves from one lane into another.

Three behaviour modes decide what happens around the shuffle. Keep mode computes only the lowest lane and preserves the old destination above it. Clear mode computes 128 or 256 bits and zeroes everything above them. Masked mode computes 128, 256 or 512 bits. It then applies a per-word write mask, either merging with the old destination or zeroing, and clears the bits above the active length. An illegal request is reported as an undefined-opcode indication and leaves the destination register untouched. An illegal request is either a set reserved-specifier flag or a length that the mode does not support.

Top module: `lane_word_shuffle`

## Requirements
- R1: In each active lane, destination word k (k = 0..3, bits [16k+15:16k] of the lane) takes source word `sel[2k+1:2k]` of the lower 64 bits of the same lane.
- R2: Bits [127:64] of every active lane equal the source bits at the same positions.
- R3: One selector drives all lanes. Lane n reads only lane n. A selector that repeats a word index is legal and raises no flag.
- R4: Keep mode (`mode` = 0) is legal only with `vlen` = 0. Only lane 0 is computed, bits 511..128 take `old_dst`, and the mask inputs are ignored.
- R5: Clear mode (`mode` = 1) is legal with `vlen` 0 (128 bits) or 1 (256 bits). Bits above the active length are zero, and the mask inputs are ignored.
- R6: In masked mode (`mode` = 2), `wmask` bit w enables word w (bits [16w+15:16w]) for the 8, 16 or 32 active words. A disabled word takes the `old_dst` word when `zeroing` = 0 and zero when `zeroing` = 1. With `mask_on` = 0 every active word is enabled.
- R7: In masked mode, bits above the active length (`vlen` 0/1/2 = 128/256/512) are zero, whatever the mask says.
- R8: A request with `spec_nz` = 1 sets `undef_op` and leaves `dst` at its previous value.
- R9: The combinations `vlen` = 3, `mode` = 3, keep mode with `vlen` ≠ 0, and clear mode with `vlen` = 2 set `undef_op` and leave `dst` unchanged.
- R10: `out_valid` is `in_valid` delayed by one clock. `dst` and `undef_op` change only on the edge after `in_valid`. A synchronous high `rst` clears `out_valid`, `undef_op` and `dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| in_valid | input | 1 | request strobe |
| src | input | 512 | source vector |
| old_dst | input | 512 | previous destination value |
| sel | input | 8 | word selector, 2 bits per destination word |
| vlen | input | 2 | 0 = 128, 1 = 256, 2 = 512 bits |
| mode | input | 2 | 0 keep, 1 clear, 2 masked |
| wmask | input | 32 | per-word write enables (masked mode) |
| zeroing | input | 1 | 1 = zero disabled words, 0 = merge |
| mask_on | input | 1 | 0 = all words enabled |
| spec_nz | input | 1 | reserved specifier field was nonzero |
| out_valid | output | 1 | result strobe |
| dst | output | 512 | registered destination vector |
| undef_op | output | 1 | last request was illegal |

## Verification
A wrong selector decode or a lane offset error shows up as a misplaced word in `dst` on the cycle right after the request. The bench sweeps every selector value against every mode/length code, so any single-bit decode fault is visible within one sweep step. A faulty length, mask or illegal-combination decode shows up at the same cycle in one of two ways. Either nonzero bits appear above the active length, or `dst` changes when `undef_op` should have held it. No internal state survives more than one request apart from `dst` itself, so faults cannot hide for longer than one transaction.

// File: rtl/lane_word_shuffle.sv
module lane_word_shuffle #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [LANES*128-1:0] src,
  input  logic [LANES*128-1:0] old_dst,
  input  logic [7:0]         sel,
  input  logic [1:0]         vlen,
  input  logic [1:0]         mode,
  input  logic [LANES*8-1:0] wmask,
  input  logic               zeroing,
  input  logic               mask_on,
  input  logic               spec_nz,
  output logic               out_valid,
  output logic [LANES*128-1:0] dst,
  output logic               undef_op
);
  localparam int W   = LANES * 128;
  localparam int NW  = LANES * 8;
  localparam int SPW = $clog2(NW) + 2;

  logic [W-1:0]   shuf, nxt;
  logic [SPW-1:0] span;
  logic           illegal, keep_m, mask_m;

  assign keep_m = (mode == 2'd0);
  assign mask_m = (mode == 2'd2);
  assign span   = SPW'(8) << vlen;

  assign illegal = spec_nz | (mode == 2'd3) | (vlen == 2'd3)
                 | (keep_m && vlen != 2'd0)
                 | (mode == 2'd1 && vlen == 2'd2);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k < 4; k++) begin : g_word
      logic [1:0] s;
      assign s = sel[2*k +: 2];
      assign shuf[l*128 + 16*k +: 16] = src[l*128 + {s, 4'b0000} +: 16];
    end
    assign shuf[l*128 + 64 +: 64] = src[l*128 + 64 +: 64];
  end

  for (genvar w = 0; w < NW; w++) begin : g_mask
    logic act, en;
    assign act = (SPW'(w) < span);
    assign en  = !mask_m || !mask_on || wmask[w];
    assign nxt[16*w +: 16] = !act ? (keep_m ? old_dst[16*w +: 16] : 16'h0)
                           : en   ? shuf[16*w +: 16]
                           : zeroing ? 16'h0 : old_dst[16*w +: 16];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      undef_op  <= 1'b0;
      dst       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        undef_op <= illegal;
        if (!illegal) dst <= nxt;
      end
    end
  end
endmodule

module lane_word_shuffle_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [LANES*128-1:0] src,
  input logic [LANES*128-1:0] old_dst,
  input logic [7:0]         sel,
  input logic [1:0]         vlen,
  input logic [1:0]         mode,
  input logic [LANES*8-1:0] wmask,
  input logic               zeroing,
  input logic               mask_on,
  input logic               spec_nz,
  input logic               out_valid,
  input logic [LANES*128-1:0] dst,
  input logic               undef_op
);
  localparam int W = LANES * 128;

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(dst) && $stable(undef_op));
  assert_spec_block_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && spec_nz) |=> undef_op && $stable(dst));
  assert_bad_len_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd1 && vlen == 2'd2) |=> undef_op && $stable(dst));
  assert_high_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !spec_nz && mode == 2'd1 && vlen == 2'd0)
      |=> dst[127:64] == $past(src[127:64]));
  assert_clear_top_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !spec_nz && mode == 2'd1 && vlen == 2'd0)
      |=> dst[W-1:128] == '0);
  assert_keep_top_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !spec_nz && mode == 2'd0 && vlen == 2'd0)
      |=> dst[W-1:128] == $past(old_dst[W-1:128]) && !undef_op);
  assert_zero_all_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !spec_nz && mode == 2'd2 && vlen != 2'd3 && mask_on && zeroing && wmask == '0)
      |=> dst == '0);
endmodule

bind lane_word_shuffle lane_word_shuffle_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/test_lane_word_shuffle.sv
`timescale 1ns/1ps
module test_lane_word_shuffle;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [511:0] src = '0, old_dst = '0;
  logic [7:0]   sel = '0;
  logic [1:0]   vlen = '0, mode = '0;
  logic [31:0]  wmask = '0;
  logic         zeroing = 1'b0, mask_on = 1'b0, spec_nz = 1'b0;
  logic         out_valid, undef_op;
  logic [511:0] dst;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0]  rs = 64'h9E3779B97F4A7C15;
  logic [511:0] exp_dst = '0;
  logic         exp_undef = 1'b0;

  always #2.5 clk = ~clk;

  lane_word_shuffle i_lane_word_shuffle (.*);

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic bit is_illegal(logic [1:0] m, logic [1:0] v, logic s);
    return s || m == 3 || v == 3 || (m == 0 && v != 0) || (m == 1 && v == 2);
  endfunction

  function automatic logic [511:0] model(logic [511:0] s, logic [511:0] o, logic [7:0] im,
                                         logic [1:0] v, logic [1:0] m, logic [31:0] mk,
                                         logic z, logic on);
    logic [511:0] r;
    int words;
    words = 8 * (1 << v);
    for (int w = 0; w < 32; w++) begin
      int l, k, from;
      logic [15:0] val;
      l = w / 8; k = w % 8;
      from = (k < 4) ? l * 8 + ((im >> (2 * k)) & 3) : w;
      val = s[16 * from +: 16];
      if (w >= words) r[16 * w +: 16] = (m == 0) ? o[16 * w +: 16] : 16'h0;
      else if (m != 2 || !on || mk[w]) r[16 * w +: 16] = val;
      else r[16 * w +: 16] = z ? 16'h0 : o[16 * w +: 16];
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [511:0] act, logic [511:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue();
    @(negedge clk);
    in_valid = 1'b1;
    if (!is_illegal(mode, vlen, spec_nz))
      exp_dst = model(src, old_dst, sel, vlen, mode, wmask, zeroing, mask_on);
    exp_undef = is_illegal(mode, vlen, spec_nz);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_common(string tag);
    check(out_valid === 1'b1, "R10 out_valid", 512'(out_valid), 512'(1));
    check(undef_op === exp_undef, {tag, " undef_op"}, 512'(undef_op), 512'(exp_undef));
    check(dst === exp_dst, {tag, " dst"}, dst, exp_dst);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid === 1'b0, "R10 reset out_valid", 512'(out_valid), 512'(0));
    check(undef_op === 1'b0, "R10 reset undef_op", 512'(undef_op), 512'(0));
    check(dst === '0, "R10 reset dst", dst, '0);

    // directed: word w of src holds 16'hA000 + w
    for (int w = 0; w < 32; w++) src[16 * w +: 16] = 16'hA000 + 16'(w);
    old_dst = '1; mode = 2; vlen = 2; mask_on = 0; spec_nz = 0; sel = 8'h1B;
    issue();
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 4; k++)
        check(dst[128 * l + 16 * k +: 16] === 16'hA000 + 16'(l * 8 + 3 - k), "R1 reversed word",
              512'(dst[128 * l + 16 * k +: 16]), 512'(16'hA000 + 16'(l * 8 + 3 - k)));
    for (int w = 0; w < 32; w++)
      if (w % 8 >= 4)
        check(dst[16 * w +: 16] === 16'hA000 + 16'(w), "R2 high quad pass",
              512'(dst[16 * w +: 16]), 512'(16'hA000 + 16'(w)));

    sel = 8'h00;
    issue();
    check(undef_op === 1'b0, "R3 repeated selector not flagged", 512'(undef_op), 512'(0));
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 4; k++)
        check(dst[128 * l + 16 * k +: 16] === 16'hA000 + 16'(l * 8), "R3 same lane broadcast",
              512'(dst[128 * l + 16 * k +: 16]), 512'(16'hA000 + 16'(l * 8)));

    vlen = 1; mask_on = 1; wmask = '0; zeroing = 0;
    issue();
    check(dst[511:256] === '0, "R7 above length cleared", 512'(dst[511:256]), '0);
    check(dst[255:0] === '1, "R6 merge keeps old", 512'(dst[255:0]), 512'({256{1'b1}}));

    exp_dst = dst;
    @(negedge clk);
    src = ~src; sel = 8'hE4;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 idle out_valid", 512'(out_valid), 512'(0));
    check(dst === exp_dst, "R10 idle hold dst", dst, exp_dst);

    for (int im = 0; im < 256; im++) begin
      for (int c = 0; c < 16; c++) begin
        string tag;
        for (int j = 0; j < 8; j++) begin
          src[64 * j +: 64] = rnd();
          old_dst[64 * j +: 64] = rnd();
        end
        sel = 8'(im); mode = 2'(c >> 2); vlen = 2'(c);
        wmask = 32'(rnd()); zeroing = rs[40]; mask_on = rs[41] | rs[42];
        spec_nz = (rs[50:47] == 4'd0);
        if (spec_nz) tag = "R8";
        else if (is_illegal(mode, vlen, 1'b0)) tag = "R9";
        else if (mode == 0) tag = "R4";
        else if (mode == 1) tag = "R5";
        else tag = "R6";
        issue();
        check_common(tag);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule